// File: doc/BRIEF.md
# Quantized Outer-Product Multiply-Accumulate Array

This block is the compute core of a machine-learning datapath. It holds a grid of 32-bit accumulators, eight rows by eight columns by default. On each step it receives one wide operand word and one narrow operand word. The wide word is split into one 32-bit lane per column, and each lane carries four signed int8 values that are broadcast down the whole column. The narrow word carries four signed int8 values from one batch. It enters a row shift chain, so each row works on a different, older batch.

Every cell forms the dot product of its row's four int8 values with its column's four int8 values. It adds that sum into its accumulator, and the addition wraps in two's complement. A clear control zeroes the array and the chain before a new tile, and it cancels any steps still in the pipeline. A read port returns one full row of accumulators per request as a single wide word, with a valid flag.

Top module: `outer_mac_array`

## Requirements
- R1: On each accepted step, cell (i,j) adds the sum over b=0..3 of signed(chain row i byte b) times signed(wide lane j byte b) to its 32-bit accumulator. Byte b of a 32-bit word sits at bits 8b+7:8b, and wide lane j sits at bits 32j+31:32j.
- R2: On each step the narrow chain shifts. Row 0 takes `narrow_i`, and row i takes the previous value of row i-1. The chain does not move without a step, so after a clear row i sees the narrow value of the step i steps earlier.
- R3: Wide lane j feeds every row of column j in the same step, and only column j.
- R4: A clear sampled at edge k sets every accumulator and every chain row to zero. It discards the steps sampled at edges k-1 and k-2. A step sampled at the same edge k is kept and loads chain row 0.
- R5: A step sampled at edge k updates the accumulators at edge k+2. A read sampled at edge m returns the accumulators as they were before the updates of edge m, so the first read that shows the step is the one sampled at k+3.
- R6: Accumulation wraps modulo 2^32.
- R7: A read request with row r sampled at an edge sets `rd_valid_o` after that edge and loads `rd_data_o` with row r, where bits 32j+31:32j hold column j. Without a request, `rd_valid_o` is low and `rd_data_o` holds its value.
- R8: During reset, all accumulators, chain rows, pipeline stages, `rd_valid_o` and `rd_data_o` are zero.
- R9: With no step and no clear, the accumulators do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_valid_i | input | 1 | Accept one operand pair and accumulate it |
| clear_i | input | 1 | Zero the accumulators and the chain, and cancel in-flight steps |
| wide_i | input | 256 | Column operand: eight lanes of four int8 values each |
| narrow_i | input | 32 | Batch operand of four int8 values, entering chain row 0 |
| rd_req_i | input | 1 | Read request |
| rd_row_i | input | 3 | Row to read |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 256 | One accumulator row, eight 32-bit lanes |

## Verification
The bound assertions check the read port on every cycle. They check that valid follows a request and that the data holds when there is no request. They check that a read issued right after a clear returns zero. They also check that two back-to-back reads of the same row agree when no step or clear could have changed it in between. The dot-product arithmetic, the row shift of the narrow batches, the column broadcast, the two-cycle latency, the cancelling of in-flight steps and the wrap after more than 32768 maximal steps need the bench. There, a reference model tracks every accumulator through directed and random scenarios.

// File: rtl/opa_pkg.sv
package opa_pkg;
  localparam int DEF_ROWS  = 8;
  localparam int DEF_COLS  = 8;
  localparam int DEF_LANES = 4;
  localparam int DEF_EW    = 8;
  localparam int DEF_AW    = 32;

  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_ZERO = 2'd2
  } acc_op_e;
endpackage

// File: rtl/opa_dot4.sv
module opa_dot4 #(
  parameter int LANES = 4,
  parameter int EW    = 8,
  parameter int AW    = 32,
  localparam int LW   = LANES * EW
) (
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  output logic [AW-1:0] dot_o
);
  logic signed [2*EW-1:0] prod [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_mul
    assign prod[l] = $signed(a_i[l*EW +: EW]) * $signed(b_i[l*EW +: EW]);
  end

  always_comb begin
    dot_o = '0;
    for (int l = 0; l < LANES; l++)
      dot_o = dot_o + {{(AW-2*EW){prod[l][2*EW-1]}}, prod[l]};
  end
endmodule

// File: rtl/opa_cell.sv
module opa_cell import opa_pkg::*; #(
  parameter int LANES = 4,
  parameter int EW    = 8,
  parameter int AW    = 32,
  localparam int LW   = LANES * EW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  input  acc_op_e       op_i,
  output logic [AW-1:0] acc_o
);
  logic [AW-1:0] dot_w, prod_q;

  opa_dot4 #(.LANES(LANES), .EW(EW), .AW(AW)) u_dot (
    .a_i  (a_i),
    .b_i  (b_i),
    .dot_o(dot_w)
  );

  // stage 2: registered dot product
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prod_q <= '0;
    else if (cap_i) prod_q <= dot_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_o <= '0;
    else begin
      unique case (op_i)
        ACC_ZERO: acc_o <= '0;
        ACC_ADD:  acc_o <= acc_o + prod_q;
        default:  acc_o <= acc_o;
      endcase
    end
  end
endmodule

// File: rtl/opa_narrow_chain.sv
module opa_narrow_chain #(
  parameter int ROWS = 8,
  parameter int LW   = 32,
  localparam int CW  = ROWS * LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          clr_i,
  input  logic [LW-1:0] din_i,
  output logic [CW-1:0] rows_o
);
  logic [CW-1:0] nxt_shift;

  if (ROWS == 1) begin : g_single
    assign nxt_shift = din_i;
  end else begin : g_multi
    assign nxt_shift = {rows_o[CW-LW-1:0], din_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rows_o <= '0;
    else if (clr_i) begin
      rows_o <= '0;
      if (shift_i) rows_o[LW-1:0] <= din_i;
    end else if (shift_i) rows_o <= nxt_shift;
  end
endmodule

// File: rtl/opa_readout.sv
module opa_readout #(
  parameter int ROWS = 8,
  parameter int DW   = 256,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ROWS*DW-1:0] acc_i,
  input  logic               req_i,
  input  logic [RW-1:0]      row_i,
  output logic               valid_o,
  output logic [DW-1:0]      data_o
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int r = 0; r < ROWS; r++)
      if (int'(row_i) == r) sel = acc_i[r*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) data_o <= sel;
    end
  end
endmodule

// File: rtl/outer_mac_array.sv
module outer_mac_array import opa_pkg::*; #(
  parameter int ROWS  = DEF_ROWS,
  parameter int COLS  = DEF_COLS,
  parameter int LANES = DEF_LANES,
  parameter int EW    = DEF_EW,
  parameter int AW    = DEF_AW,
  localparam int LW   = LANES * EW,
  localparam int WW   = COLS * LW,
  localparam int DW   = COLS * AW,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_valid_i,
  input  logic          clear_i,
  input  logic [WW-1:0] wide_i,
  input  logic [LW-1:0] narrow_i,
  input  logic          rd_req_i,
  input  logic [RW-1:0] rd_row_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o
);
  logic [WW-1:0]      wide_q;
  logic               s1_q, s2_q;
  logic [ROWS*LW-1:0] chain;
  logic [ROWS*DW-1:0] acc_flat;
  acc_op_e            acc_op;

  // stage 1: operand capture; clear cancels what is still in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      wide_q <= '0;
    end else begin
      s1_q <= step_valid_i;
      s2_q <= s1_q & ~clear_i;
      if (step_valid_i) wide_q <= wide_i;
    end
  end

  assign acc_op = clear_i ? ACC_ZERO : (s2_q ? ACC_ADD : ACC_HOLD);

  opa_narrow_chain #(.ROWS(ROWS), .LW(LW)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(step_valid_i),
    .clr_i  (clear_i),
    .din_i  (narrow_i),
    .rows_o (chain)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      opa_cell #(.LANES(LANES), .EW(EW), .AW(AW)) u_cell (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .cap_i (s1_q),
        .a_i   (chain[r*LW +: LW]),
        .b_i   (wide_q[c*LW +: LW]),
        .op_i  (acc_op),
        .acc_o (acc_flat[(r*COLS+c)*AW +: AW])
      );
    end
  end

  opa_readout #(.ROWS(ROWS), .DW(DW)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc_flat),
    .req_i  (rd_req_i),
    .row_i  (rd_row_i),
    .valid_o(rd_valid_o),
    .data_o (rd_data_o)
  );
endmodule

// File: rtl/opa_checker.sv
module opa_checker #(
  parameter int RW = 3,
  parameter int DW = 256
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          step_valid_i,
  input logic          clear_i,
  input logic          rd_req_i,
  input logic [RW-1:0] rd_row_i,
  input logic          rd_valid_o,
  input logic [DW-1:0] rd_data_o
);
  AST_RD_VALID_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o); // R7

  AST_RD_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rd_valid_o); // R7

  AST_RD_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> $stable(rd_data_o)); // R7

  AST_CLEAR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && $past(clear_i)) |=> (rd_data_o == '0)); // R4

  AST_IDLE_ACC_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && $past(rd_req_i) && (rd_row_i == $past(rd_row_i)) &&
     !$past(clear_i) && !$past(step_valid_i, 3)) |=> $stable(rd_data_o)); // R9
endmodule

bind outer_mac_array opa_checker #(.RW(RW), .DW(DW)) u_opa_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .step_valid_i(step_valid_i),
  .clear_i     (clear_i),
  .rd_req_i    (rd_req_i),
  .rd_row_i    (rd_row_i),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o)
);

// File: tb/outer_mac_array_test.sv
`timescale 1ns/1ps
module outer_mac_array_test;
  localparam int NR = 8;
  localparam int NC = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         step_valid = 1'b0;
  logic         clear = 1'b0;
  logic [255:0] wide = '0;
  logic [31:0]  narrow = '0;
  logic         rd_req = 1'b0;
  logic [2:0]   rd_row = '0;
  logic         rd_valid;
  logic [255:0] rd_data;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  logic [31:0] mch  [NR];
  logic [31:0] macc [NR][NC];

  always #10 clk = ~clk;

  outer_mac_array uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .step_valid_i(step_valid),
    .clear_i     (clear),
    .wide_i      (wide),
    .narrow_i    (narrow),
    .rd_req_i    (rd_req),
    .rd_row_i    (rd_row),
    .rd_valid_o  (rd_valid),
    .rd_data_o   (rd_data)
  );

  function automatic logic [31:0] m_dot(logic [31:0] n, logic [31:0] w);
    int s = 0;
    for (int b = 0; b < 4; b++) s = s + $signed(n[8*b +: 8]) * $signed(w[8*b +: 8]);
    return s;
  endfunction

  function automatic logic [255:0] m_row(int r);
    logic [255:0] v;
    for (int j = 0; j < NC; j++) v[32*j +: 32] = macc[r][j];
    return v;
  endfunction

  task automatic m_zero();
    for (int i = 0; i < NR; i++) begin
      mch[i] = '0;
      for (int j = 0; j < NC; j++) macc[i][j] = '0;
    end
  endtask

  task automatic m_apply(logic [31:0] n, logic [255:0] w);
    for (int i = NR-1; i > 0; i--) mch[i] = mch[i-1];
    mch[0] = n;
    for (int i = 0; i < NR; i++)
      for (int j = 0; j < NC; j++) macc[i][j] = macc[i][j] + m_dot(mch[i], w[32*j +: 32]);
  endtask

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_step(logic [31:0] n, logic [255:0] w);
    step_valid = 1'b1; narrow = n; wide = w;
    m_apply(n, w);
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  task automatic do_clear();
    clear = 1'b1;
    m_zero();
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic clear_step(logic [31:0] n, logic [255:0] w);
    clear = 1'b1; step_valid = 1'b1; narrow = n; wide = w;
    m_zero();
    m_apply(n, w);
    @(negedge clk);
    clear = 1'b0; step_valid = 1'b0;
  endtask

  task automatic read_row(int r, output logic [255:0] d, output logic v);
    rd_req = 1'b1; rd_row = 3'(r);
    @(negedge clk);
    rd_req = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic check_rows(string tag);
    logic [255:0] d;
    logic v;
    repeat (3) @(negedge clk);
    for (int r = 0; r < NR; r++) begin
      read_row(r, d, v);
      chk(tag, d, m_row(r));
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [255:0] d, d2;
    logic v;
    logic [255:0] w0;
    void'($urandom(32'd7781));
    m_zero();
    repeat (3) @(negedge clk);
    // R8: reset state at the ports
    chk("R8 rd_valid in reset", {255'd0, rd_valid}, '0);
    chk("R8 rd_data in reset", rd_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_rows("R8 accumulators after reset");

    // R5: latency of a single step
    w0 = {32'h01020304, 32'h7f7f7f7f, 32'h80808080, 32'hfffefdfc,
          32'h00000001, 32'h10203040, 32'h81ff7f01, 32'h05050505};
    do_step(32'h03fe7f80, w0);
    read_row(0, d, v); chk("R5 read at k+1 still old", d, '0);
    read_row(0, d, v); chk("R5 read at k+2 still old", d, '0);
    read_row(0, d, v); chk("R5 read at k+3 shows step", d, m_row(0));
    chk("R7 valid on request", {255'd0, v}, 256'd1);
    @(negedge clk);
    chk("R7 valid low when idle", {255'd0, rd_valid}, '0);
    chk("R7 data holds when idle", rd_data, m_row(0));

    // R1/R3: one step, per-column lanes distinct
    check_rows("R1 R3 single step products");
    chk("R3 row0 lane0 hand value", {224'd0, m_row(0)[31:0]},
        {224'd0, 32'(3*5 + (-2)*5 + 127*5 + (-128)*5)});

    // R2: three distinct batches shift through rows
    do_clear();
    do_step(32'h01010101, w0);
    do_step(32'h02020202, w0);
    do_step(32'hfdfdfdfd, w0);
    check_rows("R2 narrow chain shift");

    // R4: clear kills steps from one and two cycles before
    do_clear();
    do_step(32'h11223344, w0);
    do_clear();
    check_rows("R4 clear kills step k-1");
    do_step(32'h11223344, w0);
    @(negedge clk);
    do_clear();
    check_rows("R4 clear kills step k-2");
    do_step(32'h55667788, w0);
    clear_step(32'h7f017f01, w0);
    check_rows("R4 step with clear kept");

    // R9: idle keeps accumulators
    read_row(0, d, v);
    repeat (5) @(negedge clk);
    read_row(0, d2, v);
    chk("R9 idle no change", d2, d);

    // R1: random steps with idle gaps
    do_clear();
    for (int t = 0; t < 240; t++) begin
      do_step($urandom, rnd256());
      if (($urandom % 4) == 0) @(negedge clk);
      if ((t % 60) == 59) check_rows("R1 random accumulate");
    end

    // R6: wrap after 32770 maximal steps
    do_clear();
    for (int t = 0; t < 32770; t++) do_step(32'h80808080, {8{32'h80808080}});
    check_rows("R6 wrap all rows");
    read_row(0, d, v);
    chk("R6 row0 wrapped value", {224'd0, d[31:0]}, {224'd0, 32'h80020000});

    finish_run();
  end
endmodule